// File: doc/BRIEF.md
# Three-Wire Converter Configuration Register Bank

This block accepts configuration for a dual-channel converter over a write-only three-wire serial link made up of a serial clock, a serial data line and an active-low load strobe. The serial lines are resynchronised into the system clock domain. A receive state machine collects one 19-bit frame, which holds a 3-bit register address followed by a 16-bit data word. The data word is committed to one of eight 16-bit registers when the strobe returns high. Frames of any other length are dropped.

The register contents are decoded into registered configuration outputs. These outputs cover the following settings:
- demultiplex ratio
- Gray or binary output coding
- clock arrangement
- input crossing switch
- per-channel standby depth
- per-channel gain codes
- offset and gain trims
- the fine sampling-delay trim on channel Q
- settling trims
- data-ready delays
- the test mode

Reserved encodings are folded onto a legal setting, so every output vector always carries a valid value.

Receive states:
- `ST_IDLE`: the strobe is high.
- `ST_SHIFT`: the strobe is low and fewer than 19 bits have arrived.
- `ST_FULL`: exactly 19 bits have arrived.
- `ST_OVER`: more than 19 bits have arrived.

Transitions:
- IDLE→SHIFT when the strobe falls.
- SHIFT→FULL on the 19th serial clock rise.
- FULL→OVER on a 20th rise.
- Any state→IDLE when the strobe is high.
- Leaving FULL because the strobe is high issues the commit.

Top module: `ctl3w_regbank`

## Requirements
- R1: After reset the outputs take these values:
  - 1:1 demux, binary coding and independent clocks.
  - Input switch `00` and no standby.
  - Gain codes 8'h80 on both channels; offset and gain trims 8'h80.
  - Fine delay, settling trims, data-ready delays and test mode all zero.
- R2: While `ser_load_n` is low, bits are taken MSB first on each rising `ser_clk`. The first 3 bits are the address and the next 16 are data. On the rising edge of `ser_load_n` after exactly 19 bits, the data goes to the addressed register. Gain lives at address 2: `gain_i` = data[7:0] and `gain_q` = data[15:8].
- R3: A frame with fewer than 19 bits changes no output.
- R4: A frame with more than 19 bits changes no output.
- R5: Rising `ser_clk` edges while `ser_load_n` is high are ignored. They neither shift nor commit.
- R6: Address 0 bits [3:2] select `clk_mode`:
  - 00: independent clocks.
  - 01: one master clock, same phase.
  - 10: one master clock, opposite phase on Q.
  - 11: read back as 00.
- R7: Address 1 bits [1:0] give the standby code for channel I and bits [3:2] give it for channel Q:
  - 00: active.
  - 01: partial.
  - 10: full.
  - 11: output as 10.
- R8: Address 0 bits [5:4] select `in_switch`:
  - 00: straight.
  - 01: both channels take input I.
  - 10: both channels take input Q.
  - 11: output as 00.
- R9: Address 0 bit 0 selects 1:2 demux when 1. Bit 1 selects Gray coding when 1.
- R10: Address 7 bits [1:0] select `test_mode`:
  - 00: off.
  - 01: decimate by 16.
  - 10: built-in test.
  - 11: output as 00.
- R11: The trim registers decode as follows:
  - Address 3 holds the offsets: I in [7:0], Q in [15:8].
  - Address 4 holds the gain trims in the same layout.
  - Address 5 holds the Q fine delay in [7:0], the I settling trim in [11:8] and the Q settling trim in [15:12].
  - Address 6 holds the I data-ready delay in [3:0] and the Q data-ready delay in [7:4].
- R12: A commit changes only the fields of the addressed register. Outputs change only two clock cycles after an internal write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock |
| ser_data | input | 1 | Serial data |
| ser_load_n | input | 1 | Active-low frame strobe |
| dmux_2 | output | 1 | 1 = 1:2 demultiplex |
| gray_code | output | 1 | 1 = Gray output coding |
| clk_mode | output | 2 | Clock arrangement |
| in_switch | output | 2 | Input crossing switch |
| stby_i | output | 2 | Channel I standby code |
| stby_q | output | 2 | Channel Q standby code |
| gain_i | output | 8 | Channel I gain code |
| gain_q | output | 8 | Channel Q gain code |
| offs_i | output | 8 | Channel I offset trim |
| offs_q | output | 8 | Channel Q offset trim |
| gtrim_i | output | 8 | Channel I gain trim |
| gtrim_q | output | 8 | Channel Q gain trim |
| fine_dly_q | output | 8 | Channel Q fine sampling delay |
| settle_i | output | 4 | Channel I settling trim |
| settle_q | output | 4 | Channel Q settling trim |
| drdy_dly_i | output | 4 | Channel I data-ready delay |
| drdy_dly_q | output | 4 | Channel Q data-ready delay |
| test_mode | output | 2 | Test mode select |

## Verification
The bench builds the block with its default two-stage synchroniser and the 3-bit address and 16-bit data widths. This makes all eight registers reachable and places the accept boundary at exactly 19 bits. The serial clock runs at one eighth of the system clock, so every serial edge survives synchronisation. Frames of 1, 18, 19, 20 and 25 bits are sent, which covers the FULL and OVER states and the drop paths from SHIFT. Every reserved code is written so that each fold is observed at the outputs.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 16;
    localparam int FRAME_W  = ADDR_W + DATA_W;
    localparam int NUM_REGS = 1 << ADDR_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2,
        ST_OVER  = 2'd3
    } rx_state_e;

    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STBY  = 3'd1;
    localparam logic [ADDR_W-1:0] A_GAIN  = 3'd2;
    localparam logic [ADDR_W-1:0] A_OFFS  = 3'd3;
    localparam logic [ADDR_W-1:0] A_GTRIM = 3'd4;
    localparam logic [ADDR_W-1:0] A_DLY   = 3'd5;
    localparam logic [ADDR_W-1:0] A_DRDY  = 3'd6;
    localparam logic [ADDR_W-1:0] A_TEST  = 3'd7;

    function automatic logic [DATA_W-1:0] reg_reset(input int idx);
        case (idx)
            2, 3, 4: reg_reset = 16'h8080;
            default: reg_reset = '0;
        endcase
    endfunction

    function automatic logic [1:0] fold_sel3(input logic [1:0] code);
        fold_sel3 = (code == 2'b11) ? 2'b00 : code;
    endfunction

    function automatic logic [1:0] fold_stby(input logic [1:0] code);
        fold_stby = (code == 2'b11) ? 2'b10 : code;
    endfunction

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int           WIDTH   = 3,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx
    import ctl3w_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          sdata_s,
    input  logic          load_s,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output rx_state_e     state_o
);
    localparam int FW  = AW + DW;
    localparam int CW  = $clog2(FW + 1);
    localparam logic [CW-1:0] LAST = CW'(FW - 1);

    rx_state_e       state, state_nx;
    logic            sclk_d;
    logic            bit_stb;
    logic [CW-1:0]   bit_cnt;
    logic [FW-1:0]   shreg;

    assign bit_stb = sclk_s & ~sclk_d & ~load_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (load_s) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_SHIFT;
                ST_SHIFT: if (bit_stb && bit_cnt == LAST) state_nx = ST_FULL;
                ST_FULL:  if (bit_stb) state_nx = ST_OVER;
                ST_OVER:  state_nx = ST_OVER;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                end
                ST_SHIFT: begin
                    if (bit_stb) begin
                        shreg   <= {shreg[FW-2:0], sdata_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_FULL: begin
                    if (load_s) begin
                        wr_en   <= 1'b1;
                        wr_addr <= shreg[FW-1 -: AW];
                        wr_data <= shreg[DW-1:0];
                    end
                end
                ST_OVER: begin
                    bit_cnt <= bit_cnt;
                end
            endcase
        end
    end

    assign state_o = state;
endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
    import ctl3w_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NR = NUM_REGS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    output logic [NR-1:0][DW-1:0]  regs_o
);
    generate
        for (genvar g = 0; g < NR; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs_o[g] <= reg_reset(g);
                else if (wr_en && wr_addr == AW'(g))
                    regs_o[g] <= wr_data;
            end
        end
    endgenerate
endmodule

// File: rtl/ctl3w_decode.sv
module ctl3w_decode
    import ctl3w_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
    output logic                             dmux_2,
    output logic                             gray_code,
    output logic [1:0]                       clk_mode,
    output logic [1:0]                       in_switch,
    output logic [1:0]                       stby_i,
    output logic [1:0]                       stby_q,
    output logic [7:0]                       gain_i,
    output logic [7:0]                       gain_q,
    output logic [7:0]                       offs_i,
    output logic [7:0]                       offs_q,
    output logic [7:0]                       gtrim_i,
    output logic [7:0]                       gtrim_q,
    output logic [7:0]                       fine_dly_q,
    output logic [3:0]                       settle_i,
    output logic [3:0]                       settle_q,
    output logic [3:0]                       drdy_dly_i,
    output logic [3:0]                       drdy_dly_q,
    output logic [1:0]                       test_mode
);
    logic [DATA_W-1:0] r_mode, r_stby, r_gain, r_offs, r_gtr, r_dly, r_drdy, r_test;

    assign r_mode = regs[A_MODE];
    assign r_stby = regs[A_STBY];
    assign r_gain = regs[A_GAIN];
    assign r_offs = regs[A_OFFS];
    assign r_gtr  = regs[A_GTRIM];
    assign r_dly  = regs[A_DLY];
    assign r_drdy = regs[A_DRDY];
    assign r_test = regs[A_TEST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dmux_2     <= 1'b0;
            gray_code  <= 1'b0;
            clk_mode   <= 2'b00;
            in_switch  <= 2'b00;
            stby_i     <= 2'b00;
            stby_q     <= 2'b00;
            gain_i     <= 8'h80;
            gain_q     <= 8'h80;
            offs_i     <= 8'h80;
            offs_q     <= 8'h80;
            gtrim_i    <= 8'h80;
            gtrim_q    <= 8'h80;
            fine_dly_q <= 8'h00;
            settle_i   <= 4'h0;
            settle_q   <= 4'h0;
            drdy_dly_i <= 4'h0;
            drdy_dly_q <= 4'h0;
            test_mode  <= 2'b00;
        end else begin
            dmux_2     <= r_mode[0];
            gray_code  <= r_mode[1];
            clk_mode   <= fold_sel3(r_mode[3:2]);
            in_switch  <= fold_sel3(r_mode[5:4]);
            stby_i     <= fold_stby(r_stby[1:0]);
            stby_q     <= fold_stby(r_stby[3:2]);
            gain_i     <= r_gain[7:0];
            gain_q     <= r_gain[15:8];
            offs_i     <= r_offs[7:0];
            offs_q     <= r_offs[15:8];
            gtrim_i    <= r_gtr[7:0];
            gtrim_q    <= r_gtr[15:8];
            fine_dly_q <= r_dly[7:0];
            settle_i   <= r_dly[11:8];
            settle_q   <= r_dly[15:12];
            drdy_dly_i <= r_drdy[3:0];
            drdy_dly_q <= r_drdy[7:4];
            test_mode  <= fold_sel3(r_test[1:0]);
        end
    end
endmodule

// File: rtl/ctl3w_regbank.sv
module ctl3w_regbank
    import ctl3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_clk,
    input  logic       ser_data,
    input  logic       ser_load_n,
    output logic       dmux_2,
    output logic       gray_code,
    output logic [1:0] clk_mode,
    output logic [1:0] in_switch,
    output logic [1:0] stby_i,
    output logic [1:0] stby_q,
    output logic [7:0] gain_i,
    output logic [7:0] gain_q,
    output logic [7:0] offs_i,
    output logic [7:0] offs_q,
    output logic [7:0] gtrim_i,
    output logic [7:0] gtrim_q,
    output logic [7:0] fine_dly_q,
    output logic [3:0] settle_i,
    output logic [3:0] settle_q,
    output logic [3:0] drdy_dly_i,
    output logic [3:0] drdy_dly_q,
    output logic [1:0] test_mode
);
    logic [2:0]                       ser_s;
    logic                             sclk_s, sdata_s, load_s;
    logic                             wr_en;
    logic [ADDR_W-1:0]                wr_addr;
    logic [DATA_W-1:0]                wr_data;
    rx_state_e                        rx_state;
    logic [NUM_REGS-1:0][DATA_W-1:0]  regs;

    ctl3w_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ser_load_n, ser_data, ser_clk}),
        .d_out (ser_s)
    );

    assign sclk_s  = ser_s[0];
    assign sdata_s = ser_s[1];
    assign load_s  = ser_s[2];

    ctl3w_rx #(.AW(ADDR_W), .DW(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .sdata_s (sdata_s),
        .load_s  (load_s),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .state_o (rx_state)
    );

    ctl3w_regs #(.AW(ADDR_W), .DW(DATA_W), .NR(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs_o  (regs)
    );

    ctl3w_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .regs       (regs),
        .dmux_2     (dmux_2),
        .gray_code  (gray_code),
        .clk_mode   (clk_mode),
        .in_switch  (in_switch),
        .stby_i     (stby_i),
        .stby_q     (stby_q),
        .gain_i     (gain_i),
        .gain_q     (gain_q),
        .offs_i     (offs_i),
        .offs_q     (offs_q),
        .gtrim_i    (gtrim_i),
        .gtrim_q    (gtrim_q),
        .fine_dly_q (fine_dly_q),
        .settle_i   (settle_i),
        .settle_q   (settle_q),
        .drdy_dly_i (drdy_dly_i),
        .drdy_dly_q (drdy_dly_q),
        .test_mode  (test_mode)
    );
endmodule

// File: rtl/ctl3w_checks.sv
module ctl3w_checks
    import ctl3w_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        load_s,
    input logic        wr_en,
    input rx_state_e   rx_state,
    input logic [1:0]  clk_mode,
    input logic [1:0]  stby_i,
    input logic [1:0]  stby_q,
    input logic [1:0]  test_mode,
    input logic [83:0] cfg
);
    // R2: a write pulse follows the strobe going high
    p_wr_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(load_s) && !$past(load_s, 2)));

    // R2: one write per frame
    p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R5: with the strobe high the receiver sits in idle
    p_idle_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_s) |-> (rx_state == ST_IDLE));

    // R12: outputs move only after a write
    p_outputs_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> $past(wr_en, 2));

    // R6: reserved clock code never reaches the output
    p_clkmode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_mode != 2'b11);

    // R7: standby codes are folded
    p_stby_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_i != 2'b11) && (stby_q != 2'b11));

    // R10: reserved test code never reaches the output
    p_test_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode != 2'b11);
endmodule

bind ctl3w_regbank ctl3w_checks chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_s    (load_s),
    .wr_en     (wr_en),
    .rx_state  (rx_state),
    .clk_mode  (clk_mode),
    .stby_i    (stby_i),
    .stby_q    (stby_q),
    .test_mode (test_mode),
    .cfg       ({dmux_2, gray_code, clk_mode, in_switch, stby_i, stby_q,
                 gain_i, gain_q, offs_i, offs_q, gtrim_i, gtrim_q, fine_dly_q,
                 settle_i, settle_q, drdy_dly_i, drdy_dly_q, test_mode})
);

// File: tb/ctl3w_regbank_tb_top.sv
module ctl3w_regbank_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_load_n = 1'b1;

    logic       dmux_2, gray_code;
    logic [1:0] clk_mode, in_switch, stby_i, stby_q, test_mode;
    logic [7:0] gain_i, gain_q, offs_i, offs_q, gtrim_i, gtrim_q, fine_dly_q;
    logic [3:0] settle_i, settle_q, drdy_dly_i, drdy_dly_q;

    always #2 clk = ~clk;

    ctl3w_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load_n(ser_load_n), .dmux_2(dmux_2), .gray_code(gray_code),
        .clk_mode(clk_mode), .in_switch(in_switch), .stby_i(stby_i),
        .stby_q(stby_q), .gain_i(gain_i), .gain_q(gain_q), .offs_i(offs_i),
        .offs_q(offs_q), .gtrim_i(gtrim_i), .gtrim_q(gtrim_q),
        .fine_dly_q(fine_dly_q), .settle_i(settle_i), .settle_q(settle_q),
        .drdy_dly_i(drdy_dly_i), .drdy_dly_q(drdy_dly_q), .test_mode(test_mode)
    );

    typedef struct {
        string       tag;
        logic [83:0] exp;
    } sb_item_t;

    sb_item_t    sb_q[$];
    logic [15:0] model [8];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    function automatic logic [1:0] f3(input logic [1:0] c);
        return (c == 2'b11) ? 2'b00 : c;
    endfunction

    function automatic logic [1:0] fs(input logic [1:0] c);
        return (c == 2'b11) ? 2'b10 : c;
    endfunction

    function automatic logic [83:0] expected();
        return {model[0][0], model[0][1], f3(model[0][3:2]), f3(model[0][5:4]),
                fs(model[1][1:0]), fs(model[1][3:2]),
                model[2][7:0], model[2][15:8], model[3][7:0], model[3][15:8],
                model[4][7:0], model[4][15:8], model[5][7:0],
                model[5][11:8], model[5][15:12], model[6][3:0], model[6][7:4],
                f3(model[7][1:0])};
    endfunction

    function automatic logic [83:0] observed();
        return {dmux_2, gray_code, clk_mode, in_switch, stby_i, stby_q,
                gain_i, gain_q, offs_i, offs_q, gtrim_i, gtrim_q, fine_dly_q,
                settle_i, settle_q, drdy_dly_i, drdy_dly_q, test_mode};
    endfunction

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic push(input string tag);
        sb_item_t it;
        repeat (12) @(negedge clk);
        it.tag = tag;
        it.exp = expected();
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    // send nbits of {addr,data} MSB first; extra bits beyond 19 are zero
    task automatic send(input logic [2:0] addr, input logic [15:0] data,
                        input int nbits, input string tag);
        logic [18:0] fr;
        fr = {addr, data};
        ser_load_n = 1'b0;
        half();
        for (int i = 0; i < nbits; i++) begin
            ser_data = (i < 19) ? fr[18-i] : 1'b0;
            half();
            ser_clk = 1'b1;
            half();
            ser_clk = 1'b0;
        end
        half();
        ser_load_n = 1'b1;
        if (nbits == 19) model[addr] = data;
        push(tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (observed() !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, observed(), it.exp);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) model[k] = (k >= 2 && k <= 4) ? 16'h8080 : 16'h0000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        push("R1 reset defaults");

        send(3'd2, 16'h3C5A, 19, "R2 gain write");
        send(3'd0, 16'h0003, 19, "R9 dmux and gray set");
        send(3'd0, 16'h0004, 19, "R6 clk mode 01");
        send(3'd0, 16'h0008, 19, "R6 clk mode 10");
        send(3'd0, 16'h000C, 19, "R6 clk mode 11 folds");
        send(3'd0, 16'h0010, 19, "R8 switch 01");
        send(3'd0, 16'h0021, 19, "R8 switch 10 with R9 dmux");
        send(3'd0, 16'h0030, 19, "R8 switch 11 folds");
        send(3'd1, 16'h0009, 19, "R7 standby I partial Q full");
        send(3'd1, 16'h000F, 19, "R7 standby 11 folds");
        send(3'd1, 16'h0006, 19, "R7 standby I full Q partial");
        send(3'd3, 16'h1234, 19, "R11 offsets");
        send(3'd4, 16'hA55A, 19, "R11 gain trims");
        send(3'd5, 16'hF00D, 19, "R11 delay and settling");
        send(3'd6, 16'h00C3, 19, "R11 data-ready delays and R12 others kept");
        send(3'd7, 16'h0001, 19, "R10 test decimate");
        send(3'd7, 16'h0002, 19, "R10 test built-in");
        send(3'd7, 16'h0003, 19, "R10 test 11 folds");
        send(3'd2, 16'h1111, 18, "R3 18-bit frame dropped");
        send(3'd2, 16'h2222, 1,  "R3 1-bit frame dropped");
        send(3'd2, 16'h3333, 20, "R4 20-bit frame dropped");
        send(3'd6, 16'h4444, 25, "R4 25-bit frame dropped");

        // R5: serial clock pulses with strobe high
        for (int i = 0; i < 24; i++) begin
            ser_data = i[0];
            half();
            ser_clk = 1'b1;
            half();
            ser_clk = 1'b0;
        end
        push("R5 clocks with strobe high ignored");

        send(3'd2, 16'hFE01, 19, "R2 write after dropped frames R12");
        send(3'd7, 16'h0000, 19, "R12 test cleared others kept");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule